// File: doc/BRIEF.md
# Line Parity Byte Generator and Checker

This block handles the line-level bit-interleaved parity byte of a single STS-1 byte stream, one byte per clock. A frame strobe marks the first byte of each 9-row by 90-column frame; from there an internal position counter follows row and column on every valid byte. Parity is even, taken separately for each of the eight bit positions, over every byte of the frame except the nine section overhead bytes (rows 0-2, columns 0-2, counted from zero). The stream is taken before any scrambling.

In transmit mode the parity gathered over one frame is written into the line parity slot of the next frame. That slot is row 4, column 0, counting from zero. Every other byte passes through unchanged. In receive mode the stream passes through untouched. The byte found in the parity slot is compared with the parity of the previous frame, and the count of differing bits is reported as a 4-bit remote error value. That value is ready to be placed in the low nibble of the remote error byte sent back to the far end.

Top module: `line_bip_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout_valid` and `rei_strobe` are 0 after that edge.
- R2: With `tx_mode`=1, the byte at row 4, column 0 (zero-based) of each frame leaves as the even BIP-8 of the previous complete frame. Every other byte leaves unchanged.
- R3: Parity covers every byte on the output wire of the frame, the parity slot included, except rows 0-2 of columns 0-2. Changing only those nine bytes leaves the parity unchanged.
- R4: In the first frame after reset, the transmit parity slot carries 0x00.
- R5: `dout` and `dout_valid` follow `din` and `din_valid` by exactly one clock.
- R6: With `tx_mode`=0, every byte leaves unchanged.
- R7: With `tx_mode`=0, one clock after the parity slot byte, `rei_strobe` pulses for one cycle. `rei_value` then holds the number of set bits in (received slot byte XOR parity of the previous frame). No strobe occurs at any other time.
- R8: No parity check and no `rei_strobe` occur in the first frame after reset.
- R9: `rei_value` spans 0 to 8. A slot byte that is wrong in all eight bits reports 8.
- R10: Bytes with `din_valid`=0 do not advance the position and do not enter the parity. A `frame_sync` with `din_valid`=1 restarts the frame at row 0, column 0, and any unfinished frame leaves no parity behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_mode | input | 1 | 1 = insert parity (transmit), 0 = check parity (receive) |
| din | input | 8 | Input byte |
| din_valid | input | 1 | Input byte qualifier |
| frame_sync | input | 1 | Marks the first byte of a frame (with din_valid) |
| dout | output | 8 | Output byte, one clock later |
| dout_valid | output | 1 | Output byte qualifier |
| rei_value | output | 4 | Count of mismatched parity bits, 0 to 8 |
| rei_strobe | output | 1 | One-cycle pulse when rei_value is fresh |

## Verification
In transmit mode, frames built from distinct data seeds show whether the inserted byte follows the previous frame rather than the current one. A pair of frames that differ only in section overhead shows whether those bytes are excluded. A frame with idle gaps shows whether invalid cycles leak into the parity, and a cut-off frame followed by a fresh sync shows whether partial frames are discarded. In receive mode, slot bytes that are exact, off by two bits and fully inverted give 0, 2 and 8. The first frame after reset must give no report at all.

// File: rtl/lbip_pkg.sv
// Shared types for the line parity unit.
package lbip_pkg;
    // Per-byte position flags derived by the position tracker.
    typedef struct packed {
        logic active;   // byte is valid and belongs to a tracked frame
        logic first;    // row 0, column 0
        logic last;     // final row, final column
        logic line;     // outside the section overhead corner
        logic b2slot;   // line parity byte position
    } lbip_pos_t;

    typedef enum logic {
        LBIP_RX = 1'b0,
        LBIP_TX = 1'b1
    } lbip_mode_e;
endpackage

// File: rtl/lbip_pos_tracker.sv
// Tracks row and column of each valid byte in a frame.
// Assumes frame_sync is asserted together with din_valid on the first byte.
// Tracking starts at the first sync and then free-runs, wrapping at frame end.
module lbip_pos_tracker
    import lbip_pkg::*;
#(
    parameter int ROWS     = 9,
    parameter int COLS     = 90,
    parameter int OH_COLS  = 3,
    parameter int SOH_ROWS = 3,
    parameter int B2_ROW   = 4,
    parameter int B2_COL   = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      din_valid,
    input  logic      frame_sync,
    output lbip_pos_t pos
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);

    logic [RW-1:0] row_q, cur_row;
    logic [CW-1:0] col_q, cur_col;
    logic          locked_q;
    logic          row_end, col_end;

    // Position of the byte presented this cycle.
    always_comb begin
        cur_row = frame_sync ? '0 : row_q;
        cur_col = frame_sync ? '0 : col_q;
        row_end = (cur_row == RW'(ROWS - 1));
        col_end = (cur_col == CW'(COLS - 1));
    end

    // Flags describing the current byte.
    always_comb begin
        pos.active = din_valid && (frame_sync || locked_q);
        pos.first  = (cur_row == '0) && (cur_col == '0);
        pos.last   = row_end && col_end;
        pos.line   = (cur_row >= RW'(SOH_ROWS)) || (cur_col >= CW'(OH_COLS));
        pos.b2slot = (cur_row == RW'(B2_ROW)) && (cur_col == CW'(B2_COL));
    end

    // Advance the position on each tracked byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            col_q    <= '0;
            locked_q <= 1'b0;
        end else if (pos.active) begin
            locked_q <= 1'b1;
            if (col_end) begin
                col_q <= '0;
                row_q <= row_end ? '0 : cur_row + 1'b1;
            end else begin
                col_q <= cur_col + 1'b1;
                row_q <= cur_row;
            end
        end
    end
endmodule

// File: rtl/lbip_parity_acc.sv
// Even bit-interleaved parity accumulator over one frame.
// Restarts at the first byte and latches the result at the last byte.
// The latched value stays until the next complete frame ends.
module lbip_parity_acc #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          first,
    input  logic          last,
    input  logic          incl,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] par_q,
    output logic          par_valid
);
    logic [DW-1:0] acc_q, acc_next;

    // Running parity including the current byte.
    always_comb begin
        acc_next = (first ? '0 : acc_q) ^ (incl ? data : '0);
    end

    // Accumulate and latch the frame result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            par_q     <= '0;
            par_valid <= 1'b0;
        end else if (step) begin
            acc_q <= acc_next;
            if (last) begin
                par_q     <= acc_next;
                par_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbip_rei_calc.sv
// Counts mismatched bits between a received parity byte and the expected one.
// Registers the saturated count and a one-cycle strobe.
module lbip_rei_calc #(
    parameter int DW      = 8,
    parameter int REI_W   = 4,
    parameter int REI_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_en,
    input  logic [DW-1:0]    rx_byte,
    input  logic [DW-1:0]    expected,
    output logic             rei_strobe,
    output logic [REI_W-1:0] rei_value
);
    localparam int CNT_W = $clog2(DW + 1);

    logic [DW-1:0]    diff;
    logic [CNT_W-1:0] cnt;
    logic [REI_W-1:0] sat;

    // Population count of the difference, then saturation.
    always_comb begin
        diff = rx_byte ^ expected;
        cnt  = '0;
        for (int i = 0; i < DW; i++) begin
            cnt = cnt + CNT_W'(diff[i]);
        end
        if (int'(cnt) > REI_MAX) sat = REI_W'(REI_MAX);
        else                     sat = REI_W'(cnt);
    end

    // Register the report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rei_strobe <= 1'b0;
            rei_value  <= '0;
        end else begin
            rei_strobe <= check_en;
            if (check_en) rei_value <= sat;
        end
    end
endmodule

// File: rtl/line_bip_unit.sv
// Line parity byte generator (transmit) and checker (receive) for one STS-1.
// Assumes one byte per clock when valid and an unscrambled stream.
// Output is registered: one clock of latency on all data.
module line_bip_unit
    import lbip_pkg::*;
#(
    parameter int DW       = 8,
    parameter int ROWS     = 9,
    parameter int COLS     = 90,
    parameter int OH_COLS  = 3,
    parameter int SOH_ROWS = 3,
    parameter int B2_ROW   = 4,
    parameter int B2_COL   = 0,
    parameter int REI_W    = 4,
    parameter int REI_MAX  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_mode,
    input  logic [DW-1:0]    din,
    input  logic             din_valid,
    input  logic             frame_sync,
    output logic [DW-1:0]    dout,
    output logic             dout_valid,
    output logic [REI_W-1:0] rei_value,
    output logic             rei_strobe
);
    lbip_pos_t  pos;
    lbip_mode_e mode;
    logic [DW-1:0] par_q, wire_byte;
    logic          par_valid, check_en;

    lbip_pos_tracker #(
        .ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS),
        .SOH_ROWS(SOH_ROWS), .B2_ROW(B2_ROW), .B2_COL(B2_COL)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .din_valid(din_valid),
        .frame_sync(frame_sync), .pos(pos)
    );

    // Select the byte placed on the wire and the check condition.
    always_comb begin
        mode      = lbip_mode_e'(tx_mode);
        wire_byte = din;
        if (mode == LBIP_TX && pos.active && pos.b2slot) begin
            wire_byte = par_valid ? par_q : '0;
        end
        check_en = pos.active && pos.b2slot && (mode == LBIP_RX) && par_valid;
    end

    lbip_parity_acc #(.DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(pos.active), .first(pos.first),
        .last(pos.last), .incl(pos.line), .data(wire_byte),
        .par_q(par_q), .par_valid(par_valid)
    );

    lbip_rei_calc #(.DW(DW), .REI_W(REI_W), .REI_MAX(REI_MAX)) u_rei (
        .clk(clk), .rst_n(rst_n), .check_en(check_en), .rx_byte(din),
        .expected(par_q), .rei_strobe(rei_strobe), .rei_value(rei_value)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout       <= wire_byte;
            dout_valid <= din_valid;
        end
    end
endmodule

// File: rtl/lbip_checker.sv
// Property checker for line_bip_unit, attached by bind.
module lbip_checker #(
    parameter int DW      = 8,
    parameter int REI_W   = 4,
    parameter int REI_MAX = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_mode,
    input logic [DW-1:0]    din,
    input logic             din_valid,
    input logic [DW-1:0]    dout,
    input logic             dout_valid,
    input logic [REI_W-1:0] rei_value,
    input logic             rei_strobe
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!dout_valid && !rei_strobe));

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid |=> dout_valid);

    assert_idle_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !din_valid |=> !dout_valid);

    assert_rx_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && !tx_mode) |=> (dout == $past(din)));

    assert_strobe_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rei_strobe |-> ($past(din_valid) && !$past(tx_mode)));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rei_strobe |=> !rei_strobe);

    assert_rei_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rei_strobe |-> (rei_value <= REI_W'(REI_MAX)));
endmodule

bind line_bip_unit lbip_checker #(.DW(DW), .REI_W(REI_W), .REI_MAX(REI_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .din(din), .din_valid(din_valid),
    .dout(dout), .dout_valid(dout_valid), .rei_value(rei_value), .rei_strobe(rei_strobe)
);

// File: tb/sim_line_bip_unit.sv
module sim_line_bip_unit;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME = 810;
    localparam int SLOT  = 360;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_mode = 1'b1;
    logic [7:0] din = '0;
    logic       din_valid = 1'b0;
    logic       frame_sync = 1'b0;
    logic [7:0] dout;
    logic       dout_valid;
    logic [3:0] rei_value;
    logic       rei_strobe;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_bip_unit u0 (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .din(din),
        .din_valid(din_valid), .frame_sync(frame_sync), .dout(dout),
        .dout_valid(dout_valid), .rei_value(rei_value), .rei_strobe(rei_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; din_valid = 1'b0; frame_sync = 1'b0;
        repeat (4) @(negedge clk);
        chk(dout_valid == 1'b0 && rei_strobe == 1'b0, "R1", int'(dout_valid), 0);
        rst_n = 1'b1;
    endtask

    // Sends nbytes of a frame; checks passthrough, slot content and reports.
    task automatic send_frame(input bit tx, input int seed, input int nbytes,
                              input int gap_every, input bit soh_flip,
                              input bit ovr, input logic [7:0] ovr_val,
                              input logic [7:0] exp_b2, input bit exp_strobe,
                              input int exp_rei, input string req,
                              output logic [7:0] par);
        int pass_err = 0;
        int gap_err = 0;
        bit saw = 0;
        bit stray = 0;
        int got_rei = 0;
        logic [7:0] got_b2 = '0;
        par = '0;
        tx_mode = tx;
        for (int idx = 0; idx < nbytes; idx++) begin
            int r;
            int c;
            bit soh;
            bit slot;
            logic [7:0] b;
            r = idx / 90;
            c = idx % 90;
            soh = (r < 3) && (c < 3);
            slot = (idx == SLOT);
            b = 8'(seed * 37 + idx * 13 + (idx >> 3));
            if (soh && soh_flip) b = ~b;
            if (!tx && slot && ovr) b = ovr_val;
            if (gap_every > 0 && idx > 0 && (idx % gap_every) == 0) begin
                @(negedge clk);
                din = 8'hA5; din_valid = 1'b0; frame_sync = 1'b0;
                @(posedge clk); #1;
                if (dout_valid !== 1'b0) gap_err++;
                if (rei_strobe) stray = 1;
            end
            @(negedge clk);
            din = b; din_valid = 1'b1; frame_sync = (idx == 0);
            @(posedge clk); #1;
            if (dout_valid !== 1'b1) pass_err++;
            if (tx && slot) got_b2 = dout;
            else if (dout !== b) pass_err++;
            if (rei_strobe) begin
                if (slot) begin saw = 1; got_rei = int'(rei_value); end
                else stray = 1;
            end
            if (!soh) par ^= (tx ? dout : b);
        end
        @(negedge clk);
        din_valid = 1'b0; frame_sync = 1'b0;
        chk(pass_err == 0, tx ? "R2/R5 passthrough" : "R6/R5 passthrough", pass_err, 0);
        if (gap_every > 0) chk(gap_err == 0, "R10 idle gaps", gap_err, 0);
        if (tx && nbytes > SLOT) chk(got_b2 == exp_b2, req, int'(got_b2), int'(exp_b2));
        if (!tx) begin
            chk(saw == exp_strobe && !stray, req, int'(saw), int'(exp_strobe));
            if (exp_strobe) chk(got_rei == exp_rei, req, got_rei, exp_rei);
        end
    endtask

    logic [7:0] p1, p2, p3, p4, p5, pj, p6;
    logic [7:0] q1, q2, q3, q4;

    task automatic test_tx_first();
        send_frame(1, 1, FRAME, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R4 first slot zero", p1);
    endtask

    task automatic test_tx_next();
        send_frame(1, 2, FRAME, 0, 0, 0, 8'h00, p1, 0, 0, "R2 slot carries prior parity", p2);
        send_frame(1, 3, FRAME, 0, 0, 0, 8'h00, p2, 0, 0, "R2 second prior parity", p3);
    endtask

    task automatic test_tx_gaps();
        send_frame(1, 4, FRAME, 97, 0, 0, 8'h00, p3, 0, 0, "R10 gaps keep slot", p4);
    endtask

    task automatic test_tx_soh();
        send_frame(1, 4, FRAME, 0, 1, 0, 8'h00, p4, 0, 0, "R3 parity after gaps", p5);
        send_frame(1, 5, FRAME, 0, 0, 0, 8'h00, p5, 0, 0, "R3 section overhead excluded", p6);
    endtask

    task automatic test_tx_resync();
        send_frame(1, 6, 200, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R10 partial", pj);
        send_frame(1, 7, FRAME, 0, 0, 0, 8'h00, p6, 0, 0, "R10 partial frame discarded", p5);
    endtask

    task automatic test_rx();
        send_frame(0, 8, FRAME, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R8 no check in first frame", q1);
        send_frame(0, 9, FRAME, 0, 0, 1, q1, 8'h00, 1, 0, "R7 exact parity", q2);
        send_frame(0, 10, FRAME, 0, 0, 1, q2 ^ 8'h05, 8'h00, 1, 2, "R7 two bits off", q3);
        send_frame(0, 11, FRAME, 0, 0, 1, ~q3, 8'h00, 1, 8, "R9 all bits off", q4);
    endtask

    initial begin
        do_reset();
        test_tx_first();
        test_tx_next();
        test_tx_gaps();
        test_tx_soh();
        test_tx_resync();
        do_reset();
        test_rx();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule